// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is the data side of a small processor in which every storage element meets on one shared internal bus. It holds eight general registers, a program counter, an instruction register, a memory address register (MAR), a memory data register (MDR), an ALU operand latch Y and an ALU result latch Z. An external control sequencer drives it one control step per clock. In each step at most one source places its contents on the bus, and any number of destinations capture the bus value at the clock edge.

The ALU takes its first operand from a two-way selector, either the Y latch or the constant 4. Its second operand comes straight from the bus, and its result can only reach the bus after it has been latched into Z. Toward memory, the MAR supplies the address. The MDR has separate capture and drive controls on its bus side and on its memory side. A read or write strobe raises a pending request, which stays up until the memory answers with a completion pulse.

Top module: `sbus_datapath`

## Requirements
- R1: A synchronous active-high reset clears every register to zero and drops both memory request outputs. After reset, every source reads back as zero on the bus.
- R2: When a source's output enable and one or more destinations' input enables are high in the same cycle, each destination holds that source's value from the next clock edge on. Destinations without an input enable keep their value.
- R3: `bus_value` shows the contents of the single enabled source in the same cycle. With no output enable high it is zero.
- R4: With `sel_four`=1 the ALU's first operand is the constant 4, and with `sel_four`=0 it is the Y latch. The second operand is the bus. `z_in` captures the ALU result into Z at the clock edge.
- R5: ALU codes on `alu_op`: 0 gives first+second+`carry_in`, 1 gives first+~second+`carry_in` (a subtraction when `carry_in`=1), 2 gives first XOR second, 3 gives first AND second.
- R6: Z keeps its value on every cycle where `z_in` is low. Z reaches the bus only while `z_out` is high.
- R7: The MDR captures `mem_rdata` on `mdr_in_mem` and the bus on `mdr_in_bus`, and the memory side wins if both are high. It drives the bus on `mdr_out_bus`. `mem_wdata` carries the MDR value while `mdr_out_mem` is high and is zero otherwise.
- R8: A `rd_req` strobe sets `mem_rd` from the next cycle on, and `mem_rd` stays high until the edge at which `mem_mfc` is high. `mem_addr` always shows the MAR, so a MAR load in the strobe cycle is already visible on the request.
- R9: A `wr_req` strobe sets `mem_wr` under the same rules as R8, with `mem_mfc` ending it.
- R10: `bus_conflict` is high in any cycle where two or more output enables are high, and low otherwise.
- R11: The three-step sequence (R1 out, Y in; R2 out, select Y, add, Z in; Z out, R3 in) leaves the sum of R1 and R2 in R3.
- R12: The two-step sequence (PC out, select 4, add, Z in; Z out, PC in) advances the PC by 4 each time it runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpr_in | input | 8 | Per-register bus capture enables |
| gpr_out | input | 8 | Per-register bus drive enables |
| pc_in | input | 1 | PC captures bus |
| pc_out | input | 1 | PC drives bus |
| ir_in | input | 1 | IR captures bus |
| ir_out | input | 1 | IR drives bus |
| mar_in | input | 1 | MAR captures bus |
| mdr_in_bus | input | 1 | MDR captures bus |
| mdr_out_bus | input | 1 | MDR drives bus |
| mdr_in_mem | input | 1 | MDR captures memory read data |
| mdr_out_mem | input | 1 | MDR drives memory write data |
| y_in | input | 1 | Y captures bus |
| z_in | input | 1 | Z captures ALU result |
| z_out | input | 1 | Z drives bus |
| sel_four | input | 1 | First ALU operand: 1 = constant 4, 0 = Y |
| alu_op | input | 2 | ALU operation code |
| carry_in | input | 1 | ALU carry input |
| rd_req | input | 1 | Start memory read |
| wr_req | input | 1 | Start memory write |
| mem_addr | output | 32 | Memory address (MAR) |
| mem_rd | output | 1 | Read request pending |
| mem_wr | output | 1 | Write request pending |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_mfc | input | 1 | Memory function completed |
| bus_value | output | 32 | Current internal bus value |
| bus_conflict | output | 1 | More than one bus driver enabled |

## Verification
The bus value, `bus_conflict` and `mem_wdata` are combinational, so the bench checks them a moment after it drives the control step, in the same cycle. Register captures, Z loads and the request flags appear one edge after the step that causes them. The bench drives each step at the falling edge and reads a register back on the bus in a later step, after the rising edge that loads it. A read-back therefore always sees the state the sequence should have produced.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_XOR = 2'd2,
        OP_AND = 2'd3
    } alu_op_e;

    // sources on the bus beyond the general registers: PC, IR, MDR, Z
    localparam int unsigned EXTRA_SRC = 4;

endpackage

// File: rtl/sbus_alu.sv
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    input  logic           cin,
    output logic [W-1:0]   res
);
    logic [W-1:0] cin_ext;
    assign cin_ext = {{(W-1){1'b0}}, cin};

    always_comb begin
        unique case (op)
            OP_ADD:  res = opa + opb + cin_ext;
            OP_SUB:  res = opa + ~opb + cin_ext;
            OP_XOR:  res = opa ^ opb;
            default: res = opa & opb;
        endcase
    end
endmodule

// File: rtl/sbus_bus.sv
module sbus_bus #(
    parameter int unsigned W    = 32,
    parameter int unsigned NSRC = 12
) (
    input  logic [NSRC-1:0][W-1:0] src,
    input  logic [NSRC-1:0]        en,
    output logic [W-1:0]           bus,
    output logic                   conflict
);
    localparam int unsigned CW = $clog2(NSRC + 1);

    logic [NSRC-1:0][W-1:0] gated;

    for (genvar g = 0; g < NSRC; g++) begin : g_gate
        assign gated[g] = src[g] & {W{en[g]}};
    end

    always_comb begin
        bus = '0;
        for (int i = 0; i < NSRC; i++) begin
            bus = bus | gated[i];
        end
    end

    logic [CW-1:0] drivers;
    always_comb begin
        drivers = '0;
        for (int i = 0; i < NSRC; i++) begin
            drivers = drivers + CW'(en[i]);
        end
        conflict = (drivers > CW'(1));
    end
endmodule

// File: rtl/sbus_reqflag.sv
module sbus_reqflag (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic done,
    output logic busy
);
    typedef struct packed {
        logic busy;
    } flag_t;

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (start) begin
            fl_d.busy = 1'b1;
        end else if (done) begin
            fl_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fl_q <= '0;
        else     fl_q <= fl_d;
    end

    assign busy = fl_q.busy;
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int unsigned W    = 32,
    parameter int unsigned NREG = 8,
    parameter logic [W-1:0] STEP = 32'd4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREG-1:0] gpr_in,
    input  logic [NREG-1:0] gpr_out,
    input  logic            pc_in,
    input  logic            pc_out,
    input  logic            ir_in,
    input  logic            ir_out,
    input  logic            mar_in,
    input  logic            mdr_in_bus,
    input  logic            mdr_out_bus,
    input  logic            mdr_in_mem,
    input  logic            mdr_out_mem,
    input  logic            y_in,
    input  logic            z_in,
    input  logic            z_out,
    input  logic            sel_four,
    input  logic [1:0]      alu_op,
    input  logic            carry_in,
    input  logic            rd_req,
    input  logic            wr_req,
    output logic [W-1:0]    mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [W-1:0]    mem_wdata,
    input  logic [W-1:0]    mem_rdata,
    input  logic            mem_mfc,
    output logic [W-1:0]    bus_value,
    output logic            bus_conflict
);
    localparam int unsigned NSRC    = NREG + EXTRA_SRC;
    localparam int unsigned SRC_PC  = NREG;
    localparam int unsigned SRC_IR  = NREG + 1;
    localparam int unsigned SRC_MDR = NREG + 2;
    localparam int unsigned SRC_Z   = NREG + 3;

    typedef struct packed {
        logic [NREG-1:0][W-1:0] gpr;
        logic [W-1:0]           pc;
        logic [W-1:0]           ir;
        logic [W-1:0]           mar;
        logic [W-1:0]           mdr;
        logic [W-1:0]           y;
        logic [W-1:0]           z;
    } state_t;

    state_t st_d, st_q;

    // bus sources and drive enables
    logic [NSRC-1:0][W-1:0] drv_src;
    logic [NSRC-1:0]        drv_en;
    logic [W-1:0]           bus;

    for (genvar g = 0; g < NREG; g++) begin : g_src
        assign drv_src[g] = st_q.gpr[g];
        assign drv_en[g]  = gpr_out[g];
    end
    assign drv_src[SRC_PC]  = st_q.pc;
    assign drv_src[SRC_IR]  = st_q.ir;
    assign drv_src[SRC_MDR] = st_q.mdr;
    assign drv_src[SRC_Z]   = st_q.z;
    assign drv_en[SRC_PC]   = pc_out;
    assign drv_en[SRC_IR]   = ir_out;
    assign drv_en[SRC_MDR]  = mdr_out_bus;
    assign drv_en[SRC_Z]    = z_out;

    sbus_bus #(.W(W), .NSRC(NSRC)) u_bus (
        .src      (drv_src),
        .en       (drv_en),
        .bus      (bus),
        .conflict (bus_conflict)
    );

    // ALU with operand selector
    logic [W-1:0] alu_a;
    logic [W-1:0] alu_res;
    assign alu_a = sel_four ? STEP : st_q.y;

    sbus_alu #(.W(W)) u_alu (
        .op  (alu_op_e'(alu_op)),
        .opa (alu_a),
        .opb (bus),
        .cin (carry_in),
        .res (alu_res)
    );

    // memory request flags: index 0 read, index 1 write
    logic [1:0] req_start;
    logic [1:0] req_busy;
    assign req_start = {wr_req, rd_req};

    for (genvar r = 0; r < 2; r++) begin : g_req
        sbus_reqflag u_flag (
            .clk   (clk),
            .rst   (rst),
            .start (req_start[r]),
            .done  (mem_mfc),
            .busy  (req_busy[r])
        );
    end

    // next-state
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (gpr_in[i]) st_d.gpr[i] = bus;
        end
        if (pc_in)  st_d.pc  = bus;
        if (ir_in)  st_d.ir  = bus;
        if (mar_in) st_d.mar = bus;
        if (y_in)   st_d.y   = bus;
        if (z_in)   st_d.z   = alu_res;
        if (mdr_in_mem) begin
            st_d.mdr = mem_rdata;
        end else if (mdr_in_bus) begin
            st_d.mdr = bus;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    logic [W-1:0] z_cur;
    assign z_cur     = st_q.z;
    assign mem_addr  = st_q.mar;
    assign mem_wdata = mdr_out_mem ? st_q.mdr : '0;
    assign mem_rd    = req_busy[0];
    assign mem_wr    = req_busy[1];
    assign bus_value = bus;
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk #(
    parameter int unsigned W    = 32,
    parameter int unsigned NSRC = 12
) (
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] drv_en,
    input logic            bus_conflict,
    input logic            z_in,
    input logic [W-1:0]    z_cur,
    input logic [W-1:0]    alu_res,
    input logic            rd_req,
    input logic            wr_req,
    input logic            mem_mfc,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic            mar_in,
    input logic [W-1:0]    mem_addr,
    input logic [W-1:0]    bus_value,
    input logic            mdr_out_mem,
    input logic [W-1:0]    mem_wdata
);
    p_multi_flag_r10: assert property (@(posedge clk) disable iff (rst)
        ($countones(drv_en) > 1) |-> bus_conflict);

    p_single_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv_en) |-> !bus_conflict);

    p_zload_r4: assert property (@(posedge clk) disable iff (rst)
        z_in |=> (z_cur == $past(alu_res)));

    p_zhold_r6: assert property (@(posedge clk) disable iff (rst)
        !z_in |=> $stable(z_cur));

    p_rd_start_r8: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> mem_rd);

    p_rd_end_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_mfc && !rd_req) |=> !mem_rd);

    p_addr_new_r8: assert property (@(posedge clk) disable iff (rst)
        mar_in |=> (mem_addr == $past(bus_value)));

    p_wr_start_r9: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> mem_wr);

    p_wr_end_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_mfc && !wr_req) |=> !mem_wr);

    p_wdata_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !mdr_out_mem |-> (mem_wdata == '0));
endmodule

bind sbus_datapath sbus_datapath_chk #(.W(W), .NSRC(NSRC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .drv_en       (drv_en),
    .bus_conflict (bus_conflict),
    .z_in         (z_in),
    .z_cur        (z_cur),
    .alu_res      (alu_res),
    .rd_req       (rd_req),
    .wr_req       (wr_req),
    .mem_mfc      (mem_mfc),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .mar_in       (mar_in),
    .mem_addr     (mem_addr),
    .bus_value    (bus_value),
    .mdr_out_mem  (mdr_out_mem),
    .mem_wdata    (mem_wdata)
);

// File: tb/sim_sbus_datapath.sv
module sim_sbus_datapath;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  gpr_in = '0, gpr_out = '0;
    logic        pc_in = 0, pc_out = 0, ir_in = 0, ir_out = 0, mar_in = 0;
    logic        mdr_in_bus = 0, mdr_out_bus = 0, mdr_in_mem = 0, mdr_out_mem = 0;
    logic        y_in = 0, z_in = 0, z_out = 0, sel_four = 0, carry_in = 0;
    logic [1:0]  alu_op = '0;
    logic        rd_req = 0, wr_req = 0, mem_mfc = 0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem_addr, mem_wdata, bus_value;
    logic        mem_rd, mem_wr, bus_conflict;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] m_gpr [8];
    logic [31:0] m_pc, m_z;

    always #10 clk = ~clk;

    sbus_datapath u0 (
        .clk(clk), .rst(rst), .gpr_in(gpr_in), .gpr_out(gpr_out),
        .pc_in(pc_in), .pc_out(pc_out), .ir_in(ir_in), .ir_out(ir_out),
        .mar_in(mar_in), .mdr_in_bus(mdr_in_bus), .mdr_out_bus(mdr_out_bus),
        .mdr_in_mem(mdr_in_mem), .mdr_out_mem(mdr_out_mem), .y_in(y_in),
        .z_in(z_in), .z_out(z_out), .sel_four(sel_four), .alu_op(alu_op),
        .carry_in(carry_in), .rd_req(rd_req), .wr_req(wr_req),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_mfc(mem_mfc),
        .bus_value(bus_value), .bus_conflict(bus_conflict)
    );

    function automatic logic [31:0] alu_ref(logic [31:0] a, logic [31:0] b,
                                            logic [1:0] op, logic cin);
        case (op)
            2'd0:    return a + b + {31'd0, cin};
            2'd1:    return a + ~b + {31'd0, cin};
            2'd2:    return a ^ b;
            default: return a & b;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        gpr_in = '0; gpr_out = '0; pc_in = 0; pc_out = 0; ir_in = 0; ir_out = 0;
        mar_in = 0; mdr_in_bus = 0; mdr_out_bus = 0; mdr_in_mem = 0; mdr_out_mem = 0;
        y_in = 0; z_in = 0; z_out = 0; sel_four = 0; carry_in = 0; alu_op = '0;
        rd_req = 0; wr_req = 0; mem_mfc = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        quiet();
    endtask

    task automatic read_gpr(int k, string tag);
        gpr_out[k] = 1'b1;
        #1;
        chk(tag, bus_value, m_gpr[k]);
        gpr_out[k] = 1'b0;
    endtask

    task automatic load_gpr(int k, logic [31:0] val);
        mem_rdata = val; mdr_in_mem = 1'b1;
        tick();
        mdr_out_bus = 1'b1; gpr_in[k] = 1'b1;
        tick();
        m_gpr[k] = val;
    endtask

    task automatic alu_seq(int i, int j, int k, logic [1:0] op, logic s4, logic cin);
        logic [31:0] yv;
        yv = m_gpr[i];
        gpr_out[i] = 1'b1; y_in = 1'b1;
        tick();
        gpr_out[j] = 1'b1; sel_four = s4; alu_op = op; carry_in = cin; z_in = 1'b1;
        tick();
        m_z = alu_ref(s4 ? 32'd4 : yv, m_gpr[j], op, cin);
        z_out = 1'b1; gpr_in[k] = 1'b1;
        tick();
        m_gpr[k] = m_z;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 8; i++) m_gpr[i] = '0;
        m_pc = '0; m_z = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        quiet();

        // R1: reset state
        for (int i = 0; i < 8; i++) read_gpr(i, "R1 gpr reset");
        pc_out = 1; #1; chk("R1 pc reset", bus_value, 32'd0); pc_out = 0;
        z_out = 1; #1; chk("R1 z reset", bus_value, 32'd0); z_out = 0;
        chk("R1 mem_rd reset", {31'd0, mem_rd}, 32'd0);
        chk("R1 mem_wr reset", {31'd0, mem_wr}, 32'd0);

        // R3: idle bus is zero
        #1; chk("R3 idle bus", bus_value, 32'd0);

        // R2: transfers, including one-to-many and IR path
        load_gpr(5, 32'hDEAD_BEEF);
        read_gpr(5, "R2 load via mdr");
        gpr_out[5] = 1; gpr_in[2] = 1; gpr_in[6] = 1; ir_in = 1;
        tick();
        m_gpr[2] = 32'hDEAD_BEEF; m_gpr[6] = 32'hDEAD_BEEF;
        read_gpr(2, "R2 fanout r2");
        read_gpr(6, "R2 fanout r6");
        read_gpr(0, "R2 untouched r0");
        ir_out = 1; #1; chk("R2 ir copy", bus_value, 32'hDEAD_BEEF); ir_out = 0;

        // R10: conflict flag
        gpr_out[0] = 1; gpr_out[1] = 1; #1;
        chk("R10 two drivers", {31'd0, bus_conflict}, 32'd1);
        gpr_out[1] = 0; #1;
        chk("R10 one driver", {31'd0, bus_conflict}, 32'd0);
        gpr_out[0] = 0; pc_out = 1; z_out = 1; ir_out = 1; #1;
        chk("R10 three drivers", {31'd0, bus_conflict}, 32'd1);
        quiet(); #1;
        chk("R10 no driver", {31'd0, bus_conflict}, 32'd0);

        // R11: three-step add
        load_gpr(1, 32'h0000_1234);
        load_gpr(2, 32'hFFFF_0001);
        alu_seq(1, 2, 3, 2'd0, 1'b0, 1'b0);
        read_gpr(3, "R11 add sum");

        // R5: each op, directed edges
        load_gpr(4, 32'h0000_0005);
        load_gpr(7, 32'h0000_0007);
        alu_seq(4, 7, 0, 2'd1, 1'b0, 1'b1);
        read_gpr(0, "R5 sub borrow wrap");
        alu_seq(7, 4, 0, 2'd1, 1'b0, 1'b1);
        read_gpr(0, "R5 sub positive");
        alu_seq(4, 7, 0, 2'd0, 1'b0, 1'b1);
        read_gpr(0, "R5 add carry in");
        alu_seq(4, 7, 0, 2'd2, 1'b0, 1'b0);
        read_gpr(0, "R5 xor");
        alu_seq(4, 7, 0, 2'd3, 1'b0, 1'b0);
        read_gpr(0, "R5 and");

        // R4: constant four selected
        alu_seq(4, 7, 6, 2'd0, 1'b1, 1'b0);
        read_gpr(6, "R4 sel four");

        // R6: Z held while not loading, only on bus with z_out
        gpr_out[3] = 1; y_in = 1;
        tick();
        #1; chk("R6 z off bus", bus_value, 32'd0);
        z_out = 1; #1; chk("R6 z held", bus_value, m_z); z_out = 0;

        // R12: PC advance
        for (int n = 0; n < 3; n++) begin
            pc_out = 1; sel_four = 1; alu_op = 2'd0; z_in = 1; mar_in = 1;
            tick();
            z_out = 1; pc_in = 1;
            tick();
            m_pc = m_pc + 32'd4;
            pc_out = 1; #1; chk("R12 pc step", bus_value, m_pc); pc_out = 0;
        end

        // R8: read request, MAR loaded in strobe cycle
        gpr_out[5] = 1; mar_in = 1; rd_req = 1;
        tick();
        chk("R8 rd raised", {31'd0, mem_rd}, 32'd1);
        chk("R8 new addr", mem_addr, 32'hDEAD_BEEF);
        tick();
        chk("R8 rd held", {31'd0, mem_rd}, 32'd1);
        mem_mfc = 1; mdr_in_mem = 1; mem_rdata = 32'h0BAD_F00D;
        tick();
        chk("R8 rd dropped", {31'd0, mem_rd}, 32'd0);
        mdr_out_bus = 1; #1; chk("R8 mdr read data", bus_value, 32'h0BAD_F00D); mdr_out_bus = 0;

        // R7: MDR memory side priority and write data gating
        gpr_out[1] = 1; mdr_in_bus = 1; mdr_in_mem = 1; mem_rdata = 32'hA5A5_5A5A;
        tick();
        mdr_out_bus = 1; #1; chk("R7 mem side wins", bus_value, 32'hA5A5_5A5A); mdr_out_bus = 0;
        gpr_out[1] = 1; mdr_in_bus = 1;
        tick();
        #1; chk("R7 wdata gated", mem_wdata, 32'd0);
        mdr_out_mem = 1; #1; chk("R7 wdata driven", mem_wdata, m_gpr[1]);

        // R9: write request
        wr_req = 1;
        tick();
        chk("R9 wr raised", {31'd0, mem_wr}, 32'd1);
        chk("R9 rd idle", {31'd0, mem_rd}, 32'd0);
        mem_mfc = 1;
        tick();
        chk("R9 wr dropped", {31'd0, mem_wr}, 32'd0);

        // random ALU sequences (R5, R4, R11)
        for (int n = 0; n < 300; n++) begin
            int i, j, k;
            if (n % 7 == 0) load_gpr(int'($urandom_range(7)), $urandom());
            i = int'($urandom_range(7));
            j = int'($urandom_range(7));
            k = int'($urandom_range(7));
            alu_seq(i, j, k, 2'($urandom_range(3)), 1'($urandom_range(1)),
                    1'($urandom_range(1)));
            read_gpr(k, "R5 random alu");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule